// File: doc/BRIEF.md
# UART Control-Plane Register File

This block is the software-facing control plane of an asynchronous serial port. A simple single-cycle register bus writes and reads 32-bit words at fixed word offsets. Through this bus, software turns the transmitter and receiver on and off, reads a live status word, and manages a small set of interrupt flags. It also holds the line-format, baud-divider, control and pin-routing words that the serial engines consume.

The shift engines, the baud generator and the data buffers are outside this block. They reach it through single-cycle event pulses and steady level inputs. Command bits act only when they are written as ones, and the command word itself stores nothing. Interrupt flags are set by hardware events or through a set alias, and cleared through a clear alias. Hardware always beats a clear that arrives in the same cycle. The flags pass through an enable mask, and a registered OR of the result drives one interrupt line. A control bit selects what the transmit-buffer-level condition means: either the buffer is at most half full, or it is empty.

Top module: `uart_ctl_regfile`

## Requirements
- R1: After reset the following are all zero: both enables, all interrupt flags, the interrupt enable word, `irq`, and every configuration word.
- R2: A write to offset 0x0C acts as a command, one cycle later. Bit 0 turns the receiver on and bit 1 turns it off. Bit 2 turns the transmitter on and bit 3 turns it off. Bits written as 0 leave the state alone. When both the on bit and the off bit of one engine are written, off wins.
- R3: Reads of the command word (0x0C) and of the flag-clear alias (0x48) always return zero.
- R4: The status word at 0x10 is combinational and has these bits: bit 0 receiver enabled, bit 1 transmitter enabled, bit 5 `lvl_tx_idle`, bit 6 buffer level, bit 7 `lvl_rx_avail`. All other bits are zero.
- R5: The control word at 0x00 keeps only bit 0 and bit 12. Bit 0 drives `sync_mode`. Bit 12 selects the source of the buffer level: when 1 it is `lvl_buf_empty`, when 0 it is `lvl_buf_half`.
- R6: The flag word at 0x40 has four flags. Bit 0 is set by `ev_tx_done`, bit 1 by the buffer level being true, bit 2 by `ev_rx_word` and bit 4 by `ev_rx_overrun`. A flag is set on the clock edge after its event. Direct writes to 0x40 have no effect.
- R7: Writing ones to the set alias (0x44) sets those flags. Writing ones to the clear alias (0x48) clears them. Bit 3 and every bit above bit 4 always read as zero.
- R8: When a set (from hardware or from the set alias) and a clear hit the same flag in one cycle, the set wins. The buffer-level flag sets itself again while the level stays true.
- R9: The interrupt enable word at 0x4C keeps only the four flag positions. `irq` is a register: one cycle after the flags change, it shows the OR of the flags ANDed with their enable bits.
- R10: Three more words are stored and read back. The frame word at 0x04 keeps bits 15:0. The divider word at 0x14 keeps bits 20:6. The route word at 0x54 keeps bit 0 (`rx_pin_en`), bit 1 (`tx_pin_en`) and bits 10:8 (`pin_loc`). Offsets that are not mapped, including 0x18 and 0x34, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ev_tx_done | input | 1 | Pulse: transmission finished |
| ev_rx_word | input | 1 | Pulse: word received |
| ev_rx_overrun | input | 1 | Pulse: receive overflow |
| lvl_tx_idle | input | 1 | Level: transmitter has nothing left to send |
| lvl_rx_avail | input | 1 | Level: received data waiting |
| lvl_buf_empty | input | 1 | Level: transmit buffer empty |
| lvl_buf_half | input | 1 | Level: transmit buffer at most half full |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| sync_mode | output | 1 | Synchronous-mode select |
| frame_cfg | output | 32 | Stored frame word |
| clkdiv_cfg | output | 32 | Stored divider word |
| rx_pin_en | output | 1 | Receive pin enable |
| tx_pin_en | output | 1 | Transmit pin enable |
| pin_loc | output | 3 | Pin location select |
| irq | output | 1 | Registered interrupt request |

## Verification
A corrupted enable bit shows up in the status word on the read right after the command that caused it. A flag that is stuck or lost shows up one cycle after its event, both in the flag word and, one cycle after that, on `irq` when the flag is enabled. The bench sweeps every command value from every starting enable state. It also sweeps every set-alias pattern, every enable mask and every combination of the status inputs with both buffer-level modes. Any stuck bit, swapped bit or wrong priority therefore shows at the ports within two cycles of the access that exposes it.

// File: rtl/uart_crf_pkg.sv
package uart_crf_pkg;
   // word offsets
   localparam int OFS_CTRL   = 'h00;
   localparam int OFS_FRAME  = 'h04;
   localparam int OFS_CMD    = 'h0C;
   localparam int OFS_STAT   = 'h10;
   localparam int OFS_DIV    = 'h14;
   localparam int OFS_FLAGS  = 'h40;
   localparam int OFS_FSET   = 'h44;
   localparam int OFS_FCLR   = 'h48;
   localparam int OFS_IEN    = 'h4C;
   localparam int OFS_ROUTE  = 'h54;

   // command bits
   localparam int CMD_RX_ON  = 0;
   localparam int CMD_RX_OFF = 1;
   localparam int CMD_TX_ON  = 2;
   localparam int CMD_TX_OFF = 3;

   // status bits
   localparam int ST_RXEN  = 0;
   localparam int ST_TXEN  = 1;
   localparam int ST_IDLE  = 5;
   localparam int ST_LEVEL = 6;
   localparam int ST_RXAV  = 7;

   // flag bits
   localparam int FL_TXDONE = 0;
   localparam int FL_LEVEL  = 1;
   localparam int FL_RXWORD = 2;
   localparam int FL_OVR    = 4;
   localparam int FLAG_W    = 5;

   // control bits
   localparam int CT_SYNC  = 0;
   localparam int CT_LVSEL = 12;
endpackage

// File: rtl/uart_crf_mreg.sv
module uart_crf_mreg #(
   parameter int              W    = 32,
   parameter logic [W-1:0]    MASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= wdata & MASK;
   end

   a_r10_masked_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~MASK) == '0);
endmodule

// File: rtl/uart_crf_cmd.sv
module uart_crf_cmd #(
   parameter int W = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_wr,
   input  logic [W-1:0]  cmd_data,
   output logic          rx_en,
   output logic          tx_en
);
   import uart_crf_pkg::*;

   logic [1:0] on_req, off_req, en_q;
   assign on_req  = {cmd_data[CMD_TX_ON],  cmd_data[CMD_RX_ON]};
   assign off_req = {cmd_data[CMD_TX_OFF], cmd_data[CMD_RX_OFF]};

   for (genvar k = 0; k < 2; k++) begin : g_eng
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en_q[k] <= 1'b0;
         else if (cmd_wr && off_req[k])
            en_q[k] <= 1'b0;
         else if (cmd_wr && on_req[k])
            en_q[k] <= 1'b1;
      end
   end

   assign rx_en = en_q[0];
   assign tx_en = en_q[1];

   a_r2_rx_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_data[CMD_RX_OFF]) |=> !rx_en);
   a_r2_tx_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_data[CMD_TX_OFF]) |=> !tx_en);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr |=> ($stable(rx_en) && $stable(tx_en)));
endmodule

// File: rtl/uart_crf_flags.sv
module uart_crf_flags #(
   parameter int               FW        = 5,
   parameter logic [FW-1:0]    IMPL_MASK = 5'b10111
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [FW-1:0]  hw_set,
   input  logic [FW-1:0]  sw_set,
   input  logic [FW-1:0]  sw_clr,
   input  logic           ien_wr,
   input  logic [FW-1:0]  ien_data,
   output logic [FW-1:0]  flags,
   output logic [FW-1:0]  ien,
   output logic           irq
);
   for (genvar i = 0; i < FW; i++) begin : g_flag
      if (IMPL_MASK[i]) begin : g_impl
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       bit_q <= 1'b0;
            else if (hw_set[i] || sw_set[i])  bit_q <= 1'b1;
            else if (sw_clr[i])               bit_q <= 1'b0;
         end
         assign flags[i] = bit_q;

         a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_set[i] || sw_set[i]) |=> flags[i]);
         a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr[i] && !hw_set[i] && !sw_set[i]) |=> !flags[i]);
      end else begin : g_none
         assign flags[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien <= '0;
      else if (ien_wr) ien <= ien_data & IMPL_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(flags & ien);
   end

   a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|(flags & ien)));
   a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> !$past(|(flags & ien)));
endmodule

// File: rtl/uart_ctl_regfile.sv
module uart_ctl_regfile #(
   parameter int                  DATA_W     = 32,
   parameter int                  ADDR_W     = 8,
   parameter logic [DATA_W-1:0]   CTRL_MASK  = DATA_W'(32'h0000_1001),
   parameter logic [DATA_W-1:0]   FRAME_MASK = DATA_W'(32'h0000_FFFF),
   parameter logic [DATA_W-1:0]   DIV_MASK   = DATA_W'(32'h001F_FFC0),
   parameter logic [DATA_W-1:0]   ROUTE_MASK = DATA_W'(32'h0000_0703)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               ev_tx_done,
   input  logic               ev_rx_word,
   input  logic               ev_rx_overrun,
   input  logic               lvl_tx_idle,
   input  logic               lvl_rx_avail,
   input  logic               lvl_buf_empty,
   input  logic               lvl_buf_half,
   output logic               rx_en,
   output logic               tx_en,
   output logic               sync_mode,
   output logic [DATA_W-1:0]  frame_cfg,
   output logic [DATA_W-1:0]  clkdiv_cfg,
   output logic               rx_pin_en,
   output logic               tx_pin_en,
   output logic [2:0]         pin_loc,
   output logic               irq
);
   import uart_crf_pkg::*;

   localparam logic [FLAG_W-1:0] FLAG_IMPL = FLAG_W'((1 << FL_TXDONE) | (1 << FL_LEVEL) |
                                                     (1 << FL_RXWORD) | (1 << FL_OVR));
   localparam int NCFG = 4;

   if (DATA_W < 16) begin : g_chk_w
      $error("DATA_W must be at least 16");
   end
   if (ADDR_W < 7) begin : g_chk_a
      $error("ADDR_W must reach offset 0x54");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   // configuration words: ctrl, frame, divider, route
   localparam int CFG_OFS [NCFG] = '{OFS_CTRL, OFS_FRAME, OFS_DIV, OFS_ROUTE};
   localparam logic [DATA_W-1:0] CFG_MASK [NCFG] = '{CTRL_MASK, FRAME_MASK, DIV_MASK, ROUTE_MASK};
   logic [DATA_W-1:0] cfg_q [NCFG];

   for (genvar r = 0; r < NCFG; r++) begin : g_cfg
      uart_crf_mreg #(.W(DATA_W), .MASK(CFG_MASK[r])) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (bus_wr && hit(bus_addr, CFG_OFS[r])),
         .wdata (bus_wdata),
         .q     (cfg_q[r])
      );
   end

   assign sync_mode  = cfg_q[0][CT_SYNC];
   assign frame_cfg  = cfg_q[1];
   assign clkdiv_cfg = cfg_q[2];
   assign rx_pin_en  = cfg_q[3][0];
   assign tx_pin_en  = cfg_q[3][1];
   assign pin_loc    = cfg_q[3][10:8];

   uart_crf_cmd #(.W(DATA_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (bus_wr && hit(bus_addr, OFS_CMD)),
      .cmd_data (bus_wdata),
      .rx_en    (rx_en),
      .tx_en    (tx_en)
   );

   logic buf_level;
   assign buf_level = cfg_q[0][CT_LVSEL] ? lvl_buf_empty : lvl_buf_half;

   logic [FLAG_W-1:0] hw_set, flags, ien;
   always_comb begin
      hw_set            = '0;
      hw_set[FL_TXDONE] = ev_tx_done;
      hw_set[FL_LEVEL]  = buf_level;
      hw_set[FL_RXWORD] = ev_rx_word;
      hw_set[FL_OVR]    = ev_rx_overrun;
   end

   uart_crf_flags #(.FW(FLAG_W), .IMPL_MASK(FLAG_IMPL)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_set   (hw_set),
      .sw_set   ((bus_wr && hit(bus_addr, OFS_FSET)) ? bus_wdata[FLAG_W-1:0] : '0),
      .sw_clr   ((bus_wr && hit(bus_addr, OFS_FCLR)) ? bus_wdata[FLAG_W-1:0] : '0),
      .ien_wr   (bus_wr && hit(bus_addr, OFS_IEN)),
      .ien_data (bus_wdata[FLAG_W-1:0]),
      .flags    (flags),
      .ien      (ien),
      .irq      (irq)
   );

   logic [DATA_W-1:0] status;
   always_comb begin
      status           = '0;
      status[ST_RXEN]  = rx_en;
      status[ST_TXEN]  = tx_en;
      status[ST_IDLE]  = lvl_tx_idle;
      status[ST_LEVEL] = buf_level;
      status[ST_RXAV]  = lvl_rx_avail;
   end

   always_comb begin
      bus_rdata = '0;
      for (int r = 0; r < NCFG; r++)
         if (hit(bus_addr, CFG_OFS[r])) bus_rdata = cfg_q[r];
      if (hit(bus_addr, OFS_STAT))  bus_rdata = status;
      if (hit(bus_addr, OFS_FLAGS)) bus_rdata = DATA_W'(flags);
      if (hit(bus_addr, OFS_FSET))  bus_rdata = DATA_W'(flags);
      if (hit(bus_addr, OFS_IEN))   bus_rdata = DATA_W'(ien);
   end

   a_r3_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (hit(bus_addr, OFS_CMD) || hit(bus_addr, OFS_FCLR)) |-> bus_rdata == '0);
   a_r6_flag_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit(bus_addr, OFS_FLAGS) && hw_set == '0) |=> $stable(flags) || $past(flags) == '0);
   a_r8_level_reassert: assert property (@(posedge clk) disable iff (!rst_n)
      buf_level |=> flags[FL_LEVEL]);
endmodule

// File: tb/tb_uart_ctl_regfile.sv
module tb_uart_ctl_regfile;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0, rst_n = 0;
   logic        bus_wr = 0;
   logic [7:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic ev_tx_done = 0, ev_rx_word = 0, ev_rx_overrun = 0;
   logic lvl_tx_idle = 0, lvl_rx_avail = 0, lvl_buf_empty = 0, lvl_buf_half = 0;
   logic rx_en, tx_en, sync_mode, rx_pin_en, tx_pin_en, irq;
   logic [31:0] frame_cfg, clkdiv_cfg;
   logic [2:0]  pin_loc;

   int checks = 0, failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_ctl_regfile dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0; bus_wdata = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic report;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      report();
   end

   initial begin
      logic [31:0] v;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk("R1 rx_en", rx_en, 0);
      chk("R1 tx_en", tx_en, 0);
      chk("R1 irq", irq, 0);
      rd('h40, v); chk("R1 flags", v, 0);
      rd('h4C, v); chk("R1 ien", v, 0);
      rd('h00, v); chk("R1 ctrl", v, 0);
      rd('h54, v); chk("R1 route", v, 0);

      // R2 command sweep from every prior state
      for (int p = 0; p < 4; p++) begin
         for (int c = 0; c < 16; c++) begin
            logic erx, etx;
            wr('h0C, {28'd0, p[1] ? 2'b01 : 2'b10, p[0] ? 2'b01 : 2'b10});
            wr('h0C, 32'(c));
            erx = c[1] ? 1'b0 : (c[0] ? 1'b1 : p[0]);
            etx = c[3] ? 1'b0 : (c[2] ? 1'b1 : p[1]);
            chk("R2 rx_en", rx_en, erx);
            chk("R2 tx_en", tx_en, etx);
            rd('h10, v); chk("R4 enable status", v[1:0], {etx, erx});
         end
      end

      // R3 command and clear alias read zero
      wr('h0C, 32'h5);
      rd('h0C, v); chk("R3 cmd read", v, 0);
      rd('h48, v); chk("R3 clear read", v, 0);

      // R4/R5 status sweep with both level modes
      for (int m = 0; m < 2; m++) begin
         wr('h00, m ? 32'h1000 : 32'h0);
         for (int s = 0; s < 16; s++) begin
            logic lv;
            @(negedge clk);
            lvl_tx_idle = s[0]; lvl_rx_avail = s[1];
            lvl_buf_empty = s[2]; lvl_buf_half = s[3];
            lv = m ? s[2] : s[3];
            rd('h10, v);
            chk("R4/R5 status", v, {24'd0, 1'(s[1]), lv, 1'(s[0]), 5'd0} | {30'd0, tx_en, rx_en});
         end
      end
      @(negedge clk);
      lvl_tx_idle = 0; lvl_rx_avail = 0; lvl_buf_empty = 0; lvl_buf_half = 0;

      // R5 control masking and sync output
      wr('h00, 32'hFFFF_FFFF);
      rd('h00, v); chk("R5 ctrl mask", v, 32'h1001);
      chk("R5 sync_mode", sync_mode, 1);
      wr('h00, 32'h0);
      chk("R5 sync_mode off", sync_mode, 0);

      // R7 set alias sweep, R9 irq with full mask
      wr('h4C, 32'hFFFF_FFFF);
      rd('h4C, v); chk("R9 ien mask", v, 32'h17);
      for (int k = 0; k < 32; k++) begin
         wr('h48, 32'hFFFF_FFFF);
         wr('h44, 32'(k));
         rd('h40, v); chk("R7 set alias", v, 32'(k) & 32'h17);
         @(negedge clk);
         chk("R9 irq", irq, (k & 'h17) != 0);
      end

      // R9 mask sweep with all flags set
      wr('h44, 32'h1F);
      for (int e = 0; e < 32; e++) begin
         wr('h4C, 32'(e));
         @(negedge clk);
         chk("R9 masked irq", irq, (e & 'h17) != 0);
      end
      wr('h48, 32'h1F);
      @(negedge clk);
      chk("R9 irq cleared", irq, 0);
      rd('h40, v); chk("R7 clear all", v, 0);

      // R6 hardware events
      @(negedge clk); ev_tx_done = 1;
      @(negedge clk); ev_tx_done = 0;
      rd('h40, v); chk("R6 tx done flag", v, 32'h1);
      @(negedge clk); ev_rx_word = 1;
      @(negedge clk); ev_rx_word = 0;
      rd('h40, v); chk("R6 rx word flag", v, 32'h5);
      @(negedge clk); ev_rx_overrun = 1;
      @(negedge clk); ev_rx_overrun = 0;
      rd('h40, v); chk("R6 overrun flag", v, 32'h15);
      wr('h40, 32'h0);
      rd('h40, v); chk("R6 flag write ignored", v, 32'h15);
      wr('h48, 32'h1F);

      // R8 hardware set beats clear in the same cycle
      @(negedge clk);
      ev_tx_done = 1; bus_wr = 1; bus_addr = 'h48; bus_wdata = 32'h1;
      @(negedge clk);
      ev_tx_done = 0; bus_wr = 0; bus_wdata = 0;
      rd('h40, v); chk("R8 set wins", v, 32'h1);
      wr('h48, 32'h1);
      rd('h40, v); chk("R8 later clear", v, 32'h0);

      // R8 level flag re-asserts while true
      @(negedge clk); lvl_buf_half = 1;
      @(negedge clk);
      rd('h40, v); chk("R8 level flag set", v, 32'h2);
      wr('h48, 32'h2);
      rd('h40, v); chk("R8 level reasserts", v, 32'h2);
      lvl_buf_half = 0;
      wr('h48, 32'h2);
      rd('h40, v); chk("R8 level cleared", v, 32'h0);

      // R10 storage words and unmapped offsets
      wr('h04, 32'hFFFF_FFFF);
      rd('h04, v); chk("R10 frame", v, 32'h0000_FFFF);
      chk("R10 frame out", frame_cfg, 32'h0000_FFFF);
      wr('h14, 32'hFFFF_FFFF);
      rd('h14, v); chk("R10 divider", v, 32'h001F_FFC0);
      chk("R10 divider out", clkdiv_cfg, 32'h001F_FFC0);
      wr('h54, 32'h0000_0502);
      rd('h54, v); chk("R10 route", v, 32'h502);
      chk("R10 pins", {29'd0, pin_loc}, 32'h5);
      chk("R10 pin en", {30'd0, tx_pin_en, rx_pin_en}, 32'h2);
      rd('h18, v); chk("R10 unmapped 0x18", v, 0);
      rd('h34, v); chk("R10 unmapped 0x34", v, 0);

      report();
   end
endmodule